// File: doc/BRIEF.md
# Camera Raster Sync Timing Generator

This block produces the frame and line timing for a camera pixel stream. It steps a column counter and a row counter on a pixel-period tick. From their values it derives four signals: a vertical sync pulse at the top of each frame, a horizontal reference strobe that marks valid pixels on a line, a data-valid strobe, and the current column and row indices. Downstream formatting logic uses these signals to frame the pixel bytes it sends out.

Three raster geometries are available: full resolution, quarter resolution and a CIF-sized raster. Each geometry has its own line length, active width, sync length, porches and active row count. A format input chooses raw data, where one pixel period is one clock, or YUV/RGB data, where one pixel period is two clocks. A mode or format request is only accepted when a frame wraps, so a frame is never cut short or stretched partway through.

Top module: `cam_sync_gen`

## Requirements
- R1: The column index counts 0 up to line length minus 1, then returns to 0. Line length is 784 (full), 608 (quarter) or 608 (CIF) pixel periods.
- R2: The row index advances when the column wraps and counts 0 up to frame length minus 1. Frame length is 510 lines (full) or 328 lines (quarter and CIF).
- R3: `vsync_o` is high exactly while the row index is below the sync length. The sync length is 4 lines (full) or 3 lines (quarter and CIF).
- R4: The active rows begin after the sync lines plus a back porch of 11 (full) or 12 (quarter, CIF) lines. They last 480, 240 or 288 rows respectively. On an active row, `href_o` is high for columns below the active width, which is 640, 320 or 352.
- R5: `data_valid_o` is high only on active columns of active rows. It never depends on `href_always_i`.
- R6: When `href_always_i` is 1, `href_o` is also high on the active columns of rows outside the active window. When it is 0, `href_o` stays low on those rows.
- R7: With `fmt_yuv_i` = 0, the counters advance every clock. With `fmt_yuv_i` = 1, they advance every second clock, so each index value is held for two clocks.
- R8: `mode_i` and `fmt_yuv_i` are sampled only in reset and at the frame wrap, which is the last column of the last row. Changes at any other time have no effect until that point, and the counters restart at row 0, column 0 with the new geometry.
- R9: `mode_i` encoding: 0 = full, 1 = quarter, 2 = CIF, 3 = treated as full.
- R10: While `rst` is high, all outputs are 0 on the next clock. The first outputs after reset show row 0, column 0 with `vsync_o` high.
- R11: All outputs are registered. They show the counter state of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Raster geometry select (R9 encoding) |
| fmt_yuv_i | input | 1 | 1 = YUV/RGB (two clocks per pixel), 0 = raw |
| href_always_i | input | 1 | Keep line strobe on non-active rows |
| vsync_o | output | 1 | Vertical sync pulse |
| href_o | output | 1 | Horizontal reference (line-valid) strobe |
| data_valid_o | output | 1 | Pixel data valid |
| col_o | output | COL_W | Current column index |
| row_o | output | ROW_W | Current row index |

## Verification
The bench overrides every geometry parameter with small values. With these, a full-mode frame is 8 lines of 10 periods, a quarter frame 8 lines of 8, and a CIF frame 7 lines of 9. Each frame therefore completes in tens to a few hundred clocks. Short frames make it practical to cover many frame wraps, mode and format changes requested in the middle of a frame, the switch from raw to YUV timing, the mode value 3, and a reset in the middle of a frame, all within one short run. The line-strobe option is also turned on and off across whole frames. The default geometries are never reached, but they use the same code paths.

// File: rtl/cam_sync_pkg.sv
package cam_sync_pkg;
  localparam int TW = 16;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_QUARTER = 2'd1,
    MODE_CIF     = 2'd2,
    MODE_SPARE   = 2'd3
  } mode_e;

  // Geometry of one raster, all in pixel periods or lines.
  typedef struct packed {
    logic [TW-1:0] line_len;
    logic [TW-1:0] act_cols;
    logic [TW-1:0] vs_lines;
    logic [TW-1:0] act_start;
    logic [TW-1:0] act_end;
    logic [TW-1:0] frame_len;
  } raster_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/cam_pix_tick.sv
module cam_pix_tick (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic dbl,
  output logic tick
);
  logic phase;

  assign tick = dbl ? phase : 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart || tick) phase <= 1'b0;
    else                        phase <= 1'b1;
  end

  // R7: in double mode a tick is never followed directly by another tick
  p_no_back_to_back_r7: assert property (@(posedge clk) disable iff (rst)
    (dbl && tick && !restart) |=> !tick);
endmodule

// File: rtl/cam_raster_cnt.sv
module cam_raster_cnt
  import cam_sync_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  raster_t       cfg_in,
  input  logic          fmt_in,
  output raster_t       cfg_q,
  output logic          fmt_q,
  output logic [TW-1:0] col,
  output logic [TW-1:0] row,
  output logic          frame_end
);
  logic last_col, last_row;

  assign last_col  = (col == cfg_q.line_len  - TW'(1));
  assign last_row  = (row == cfg_q.frame_len - TW'(1));
  assign frame_end = tick && last_col && last_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      col   <= '0;
      row   <= '0;
      cfg_q <= cfg_in;
      fmt_q <= fmt_in;
    end else if (tick) begin
      if (last_col) begin
        col <= '0;
        if (last_row) begin
          row   <= '0;
          cfg_q <= cfg_in;
          fmt_q <= fmt_in;
        end else begin
          row <= row + TW'(1);
        end
      end else begin
        col <= col + TW'(1);
      end
    end
  end

  p_col_range_r1: assert property (@(posedge clk) disable iff (rst)
    col < cfg_q.line_len);
  p_row_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (row == '0) && (col == '0));
  p_hold_yuv_r7: assert property (@(posedge clk) disable iff (rst)
    (fmt_q && !tick) |=> (col == $past(col)) && (row == $past(row)));
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(cfg_q) && $stable(fmt_q));
endmodule

// File: rtl/cam_sync_gen.sv
module cam_sync_gen
  import cam_sync_pkg::*;
#(
  parameter int FULL_LINE  = 784,
  parameter int FULL_ACT   = 640,
  parameter int FULL_VS    = 4,
  parameter int FULL_VBP   = 11,
  parameter int FULL_ROWS  = 480,
  parameter int FULL_VFP   = 15,
  parameter int QTR_LINE   = 608,
  parameter int QTR_ACT    = 320,
  parameter int QTR_VS     = 3,
  parameter int QTR_VBP    = 12,
  parameter int QTR_ROWS   = 240,
  parameter int QTR_VFP    = 73,
  parameter int CIF_LINE   = 608,
  parameter int CIF_ACT    = 352,
  parameter int CIF_VS     = 3,
  parameter int CIF_VBP    = 12,
  parameter int CIF_ROWS   = 288,
  parameter int CIF_VFP    = 25,
  localparam int FULL_FRM  = FULL_VS + FULL_VBP + FULL_ROWS + FULL_VFP,
  localparam int QTR_FRM   = QTR_VS + QTR_VBP + QTR_ROWS + QTR_VFP,
  localparam int CIF_FRM   = CIF_VS + CIF_VBP + CIF_ROWS + CIF_VFP,
  localparam int COL_W     = $clog2(max3(FULL_LINE, QTR_LINE, CIF_LINE)),
  localparam int ROW_W     = $clog2(max3(FULL_FRM, QTR_FRM, CIF_FRM))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             fmt_yuv_i,
  input  logic             href_always_i,
  output logic             vsync_o,
  output logic             href_o,
  output logic             data_valid_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);
  raster_t       cfg_sel, cfg_cur;
  logic          fmt_cur, tick, frame_end;
  logic [TW-1:0] col, row;

  function automatic raster_t mk(input int ln, input int ac, input int vs,
                                 input int bp, input int rows, input int fp);
    raster_t r;
    r.line_len  = TW'(ln);
    r.act_cols  = TW'(ac);
    r.vs_lines  = TW'(vs);
    r.act_start = TW'(vs + bp);
    r.act_end   = TW'(vs + bp + rows);
    r.frame_len = TW'(vs + bp + rows + fp);
    return r;
  endfunction

  always_comb begin
    case (mode_e'(mode_i))
      MODE_QUARTER: cfg_sel = mk(QTR_LINE, QTR_ACT, QTR_VS, QTR_VBP, QTR_ROWS, QTR_VFP);
      MODE_CIF:     cfg_sel = mk(CIF_LINE, CIF_ACT, CIF_VS, CIF_VBP, CIF_ROWS, CIF_VFP);
      default:      cfg_sel = mk(FULL_LINE, FULL_ACT, FULL_VS, FULL_VBP, FULL_ROWS, FULL_VFP);
    endcase
  end

  cam_pix_tick u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (frame_end),
    .dbl     (fmt_cur),
    .tick    (tick)
  );

  cam_raster_cnt u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cfg_in    (cfg_sel),
    .fmt_in    (fmt_yuv_i),
    .cfg_q     (cfg_cur),
    .fmt_q     (fmt_cur),
    .col       (col),
    .row       (row),
    .frame_end (frame_end)
  );

  logic act_row, act_col;
  assign act_row = (row >= cfg_cur.act_start) && (row < cfg_cur.act_end);
  assign act_col = (col < cfg_cur.act_cols);

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_o      <= 1'b0;
      href_o       <= 1'b0;
      data_valid_o <= 1'b0;
      col_o        <= '0;
      row_o        <= '0;
    end else begin
      vsync_o      <= (row < cfg_cur.vs_lines);
      href_o       <= act_col && (act_row || href_always_i);
      data_valid_o <= act_col && act_row;
      col_o        <= col[COL_W-1:0];
      row_o        <= row[ROW_W-1:0];
    end
  end

  p_dv_inside_href_r5: assert property (@(posedge clk) disable iff (rst)
    data_valid_o |-> href_o);
  p_no_dv_in_sync_r3: assert property (@(posedge clk) disable iff (rst)
    vsync_o |-> !data_valid_o);
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> !vsync_o && !href_o && !data_valid_o && (col_o == '0) && (row_o == '0));
  p_first_after_reset_r10: assert property (@(posedge clk)
    (!rst && $past(rst)) |=> vsync_o && (row_o == '0) && (col_o == '0));
endmodule

// File: tb/cam_sync_gen_bench.sv
module cam_sync_gen_bench;
  localparam int FL = 10, FA = 6, FV = 2, FB = 1, FR = 4, FP = 1;
  localparam int QL = 8,  QA = 4, QV = 1, QB = 2, QR = 3, QP = 2;
  localparam int CL = 9,  CA = 5, CV = 1, CB = 1, CR = 2, CP = 3;
  localparam int COL_W = 4, ROW_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic fmt = 1'b0, hal = 1'b0;
  logic vs, hr, dv;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;

  always #2.5 clk = ~clk;

  cam_sync_gen #(
    .FULL_LINE(FL), .FULL_ACT(FA), .FULL_VS(FV), .FULL_VBP(FB), .FULL_ROWS(FR), .FULL_VFP(FP),
    .QTR_LINE(QL),  .QTR_ACT(QA),  .QTR_VS(QV),  .QTR_VBP(QB),  .QTR_ROWS(QR),  .QTR_VFP(QP),
    .CIF_LINE(CL),  .CIF_ACT(CA),  .CIF_VS(CV),  .CIF_VBP(CB),  .CIF_ROWS(CR),  .CIF_VFP(CP)
  ) u_cam_sync_gen (
    .clk(clk), .rst(rst), .mode_i(mode), .fmt_yuv_i(fmt), .href_always_i(hal),
    .vsync_o(vs), .href_o(hr), .data_valid_o(dv), .col_o(col), .row_o(row)
  );

  typedef struct packed {
    logic vs, hr, dv;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
  } exp_t;

  exp_t sb[$];
  int n_run = 0, n_fail = 0, cyc = 0;

  // Reference model state
  int m_col = 0, m_row = 0, m_ph = 0, m_mode = 0, m_fmt = 0;

  task automatic geom(input int md, output int ln, output int ac, output int vsl,
                      output int as, output int ae, output int fr);
    case (md)
      1: begin ln = QL; ac = QA; vsl = QV; as = QV + QB; ae = as + QR; fr = ae + QP; end
      2: begin ln = CL; ac = CA; vsl = CV; as = CV + CB; ae = as + CR; fr = ae + CP; end
      default: begin ln = FL; ac = FA; vsl = FV; as = FV + FB; ae = as + FR; fr = ae + FP; end
    endcase
  endtask

  // Driver: predicts the registered outputs after each edge (R11)
  always @(posedge clk) begin
    exp_t e;
    int ln, ac, vsl, as, ae, fr;
    bit ar, ak, stepped;
    if (rst) begin
      e = '0;
      m_col = 0; m_row = 0; m_ph = 0; m_mode = int'(mode); m_fmt = int'(fmt);
    end else begin
      geom(m_mode, ln, ac, vsl, as, ae, fr);
      ar = (m_row >= as) && (m_row < ae);
      ak = (m_col < ac);
      e.vs  = (m_row < vsl);
      e.hr  = ak && (ar || hal);
      e.dv  = ak && ar;
      e.col = m_col[COL_W-1:0];
      e.row = m_row[ROW_W-1:0];
      stepped = (m_fmt == 0) || (m_ph == 1);
      if (stepped) begin
        m_ph = 0;
        if (m_col == ln - 1) begin
          m_col = 0;
          if (m_row == fr - 1) begin
            m_row = 0; m_mode = int'(mode); m_fmt = int'(fmt);
          end else m_row = m_row + 1;
        end else m_col = m_col + 1;
      end else m_ph = 1;
    end
    sb.push_back(e);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk(vs  == e.vs,  "R3 vsync",               vs,  e.vs);
      chk(hr  == e.hr,  "R4/R6 href",             hr,  e.hr);
      chk(dv  == e.dv,  "R5 data_valid",          dv,  e.dv);
      chk(col == e.col, "R1/R7/R8/R9 column",     col, e.col);
      chk(row == e.row, "R2/R7/R8/R9 row",        row, e.row);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    run(3);
    rst = 1'b0;
    run(1);
    // R10: first output after reset is row 0, column 0, sync high
    chk(vs == 1'b1 && row == '0 && col == '0, "R10 first after reset", vs, 1);
    run(200);                       // R1 R2 R3 R4 full raw
    mode = 2'd1; fmt = 1'b1;        // R8 mid-frame request
    run(37);
    run(400);                       // R7 quarter yuv
    hal = 1'b1;                     // R6
    run(300);
    mode = 2'd2; fmt = 1'b0;        // CIF raw
    run(300);
    hal = 1'b0; mode = 2'd3; fmt = 1'b1; // R9 spare code -> full
    run(400);
    rst = 1'b1;                     // R10 mid-frame reset
    run(1);
    chk(vs == 1'b0 && hr == 1'b0 && dv == 1'b0 && col == '0 && row == '0,
        "R10 outputs cleared", {vs, hr, dv}, 0);
    rst = 1'b0; mode = 2'd2;
    run(300);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule